// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines and presents the most urgent unmasked one to a processor on a single interrupt output. The processor then pulses a one-cycle acknowledge and reads back an 8-bit vector that names the line it is about to service. The block tracks which lines are waiting, which are being serviced and which are masked. It resolves among them with a fixed priority in which line 0 wins. It is programmed through a byte-wide host port whose one-bit address picks a command register or a data register.

Software brings the block up with a short sequence of configuration bytes. A command write with bit 4 set opens the sequence, and the following data writes supply the vector base, a cascade byte, and optionally a mode byte. After that, data writes set the mask, and command writes either retire an in-service level or choose what a command read returns. A request that drops before it is acknowledged gets a lowest-priority stand-in vector, and no line is marked as in service. Each line can be sampled on its rising edge or followed as a level. A parameter lists the lines that may only be edge-sampled.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is low, a data-port read returns 0xFF (all masked), a command-port read returns the request register, and the in-service register is zero.
- R2: A command write with bit 4 set starts configuration. The next data write sets the vector base to its bits 7:3, and the one after that is the cascade byte. A mode byte follows only if bit 0 of the starting byte was 1. Without a mode byte, the next data write loads the mask and automatic retire is off.
- R3: Outside configuration, a data write loads the mask and a data read returns it unchanged. A masked line never raises `irq_out`, and a mask of 0xFF holds `irq_out` low.
- R4: Priority is fixed with line 0 highest. The acknowledge vector is {base[7:3], level[2:0]}, and it is valid during the cycle in which `irq_ack` is high.
- R5: An acknowledge of a real request clears that line's request bit and sets its in-service bit. A request is presented only if no in-service bit at its own or a higher priority is set, so a lower in-service level does not block it.
- R6: A command write of 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R7: A command write of 0x0B makes later command reads return the in-service register, and 0x0A makes them return the request register.
- R8: When bit 1 of the mode byte is set, acknowledges leave the in-service register unchanged.
- R9: If no request is being presented when `irq_ack` pulses, the vector is {base[7:3], 3'd7}, and the in-service register is unchanged. This also holds when line 7 is masked.
- R10: An edge-sampled line latches a request on a rising input. A line held high after its acknowledge does not request again until it has gone low and risen again. A request whose input falls before acknowledge is withdrawn.
- R11: A line whose `trig_level` bit is 1 is level-sampled: its request bit follows the input, so it requests again after its in-service bit is retired while the input stays high. Lines set in the parameter EDGE_ONLY (default lines 0 to 2) stay edge-sampled whatever `trig_level` says.
- R12: Starting configuration clears the in-service register, sets the mask to 0xFF, and returns command reads to the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_a0 | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the register selected by host_a0 |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line sampling select: 1 level, 0 edge |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_ack | input | 1 | One-cycle acknowledge |
| ack_vec | output | 8 | Vector, valid while irq_ack is high |

## Verification
The bench targets nesting. A lower level that is in service must not hide a higher request; a design that compared priorities the wrong way would stall line 1 behind line 5. It withdraws a request before acknowledge with line 7 masked. A design that reused a stale winner would mark a line in service and return the wrong vector. It holds edge-sampled lines high across an acknowledge, where a level-style design would fire twice. It also checks that a reserved line ignores the level select. It reruns configuration with and without the mode byte, so an off-by-one in the sequencer shows up as a mask or base read back in the wrong place.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NLINES = 8;
  localparam int LVL_W  = $clog2(NLINES);

  typedef enum logic [1:0] {CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE} cfg_state_t;

  // lowest set index (highest priority); 0 when none set
  function automatic logic [LVL_W-1:0] top_level(input logic [NLINES-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (v[i]) r = LVL_W'(i);
    return r;
  endfunction

  // bits 0..lvl set: levels that block a request at lvl
  function automatic logic [NLINES-1:0] block_mask(input logic [LVL_W-1:0] lvl);
    logic [NLINES-1:0] m;
    for (int i = 0; i < NLINES; i++)
      m[i] = (LVL_W'(i) <= lvl);
    return m;
  endfunction

  function automatic logic [7:0] make_vec(input logic [7:LVL_W] base, input logic [LVL_W-1:0] lvl);
    return {base, lvl};
  endfunction
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              a0,
  input  logic [7:0]        wdata,
  output logic [NLINES-1:0] imr,
  output logic [7:LVL_W]    base,
  output logic              aeoi,
  output logic              rd_isr,
  output logic              init_start,
  output logic              eoi_fire,
  output logic [LVL_W-1:0]  eoi_lvl
);
  cfg_state_t st_q;
  logic       need_mode_q;
  logic       cmd_wr, data_wr, sel_wr;

  assign cmd_wr     = wr && !a0;
  assign data_wr    = wr && a0;
  assign init_start = cmd_wr && wdata[4];
  assign eoi_fire   = cmd_wr && (wdata[7:5] == 3'b011) && (wdata[4:3] == 2'b00);
  assign eoi_lvl    = wdata[LVL_W-1:0];
  assign sel_wr     = cmd_wr && (wdata[4:3] == 2'b01) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= CFG_RUN;
      need_mode_q <= 1'b0;
      imr         <= '1;
      base        <= '0;
      aeoi        <= 1'b0;
      rd_isr      <= 1'b0;
    end else if (init_start) begin
      st_q        <= CFG_BASE;
      need_mode_q <= wdata[0];
      imr         <= '1;
      aeoi        <= 1'b0;
      rd_isr      <= 1'b0;
    end else begin
      if (sel_wr) rd_isr <= wdata[0];
      if (data_wr) begin
        unique case (st_q)
          CFG_RUN:  imr <= wdata;
          CFG_BASE: begin base <= wdata[7:LVL_W]; st_q <= CFG_CASC; end
          CFG_CASC: st_q <= need_mode_q ? CFG_MODE : CFG_RUN;
          CFG_MODE: begin aeoi <= wdata[1]; st_q <= CFG_RUN; end
        endcase
      end
    end
  end

  AST_INIT_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (imr == '1) && !rd_isr); // R12
  AST_SELECT_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (wdata == 8'h0B) |=> rd_isr); // R7
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
#(
  parameter logic [NLINES-1:0] EDGE_ONLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [NLINES-1:0] trig_level,
  input  logic [NLINES-1:0] clr,
  output logic [NLINES-1:0] irr
);
  logic [NLINES-1:0] prev_q, lvl_mode, rise;

  assign lvl_mode = trig_level & ~EDGE_ONLY;
  assign rise     = irq_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)            irr[g] <= 1'b0;
      else if (lvl_mode[g])  irr[g] <= irq_in[g];
      else                   irr[g] <= ((irr[g] && !clr[g]) || rise[g]) && irq_in[g];
    end
  end

  AST_EDGE_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    clr[NLINES-1] && !lvl_mode[NLINES-1] |=> !irr[NLINES-1]); // R10
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] imr,
  input  logic [NLINES-1:0] isr,
  output logic              int_req,
  output logic [LVL_W-1:0]  win_lvl
);
  logic [NLINES-1:0] pend;

  assign pend    = irr & ~imr;
  assign win_lvl = top_level(pend);
  assign int_req = (|pend) && !(|(isr & block_mask(win_lvl)));

  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_req); // R3
  AST_NESTING_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && (isr != '0) |-> top_level(isr) > win_lvl); // R5
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter logic [7:0] EDGE_ONLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_a0,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [7:0] irq_in,
  input  logic [7:0] trig_level,
  output logic       irq_out,
  input  logic       irq_ack,
  output logic [7:0] ack_vec
);
  logic [NLINES-1:0] imr, irr, isr_q, win_oh, clr_irr, eoi_oh;
  logic [7:LVL_W]    base;
  logic              aeoi, rd_isr, init_start, eoi_fire, int_req, real_ack;
  logic [LVL_W-1:0]  eoi_lvl, win_lvl;

  pic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .a0(host_a0), .wdata(host_wdata),
    .imr(imr), .base(base), .aeoi(aeoi), .rd_isr(rd_isr),
    .init_start(init_start), .eoi_fire(eoi_fire), .eoi_lvl(eoi_lvl)
  );

  pic_req #(.EDGE_ONLY(EDGE_ONLY)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
    .clr(clr_irr), .irr(irr)
  );

  pic_resolve u_res (
    .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .isr(isr_q),
    .int_req(int_req), .win_lvl(win_lvl)
  );

  assign real_ack = irq_ack && int_req;
  assign win_oh   = NLINES'(1) << win_lvl;
  assign eoi_oh   = eoi_fire ? (NLINES'(1) << eoi_lvl) : '0;
  assign clr_irr  = real_ack ? win_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || init_start) isr_q <= '0;
    else isr_q <= (isr_q & ~eoi_oh) | ((real_ack && !aeoi) ? win_oh : '0);
  end

  assign irq_out    = int_req;
  assign ack_vec    = make_vec(base, real_ack ? win_lvl : LVL_W'(NLINES - 1));
  assign host_rdata = host_a0 ? imr : (rd_isr ? isr_q : irr);

  AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && int_req && !aeoi && !eoi_fire && !init_start
      |=> (isr_q & $past(win_oh)) != '0); // R5
  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !int_req && !eoi_fire && !init_start |=> isr_q == $past(isr_q)); // R9
  AST_AUTO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && aeoi && !eoi_fire && !init_start |=> isr_q == $past(isr_q)); // R8
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire && !irq_ack |=> !isr_q[$past(eoi_lvl)]); // R6
  AST_INIT_CLEARS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> isr_q == '0); // R12
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host_wr = 1'b0, host_a0 = 1'b0, irq_ack = 1'b0;
  logic [7:0] host_wdata = '0, irq_in = '0, trig_level = '0;
  logic [7:0] host_rdata, ack_vec;
  logic       irq_out;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       mon_ev;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_a0(host_a0),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
    .trig_level(trig_level), .irq_out(irq_out), .irq_ack(irq_ack), .ack_vec(ack_vec)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a0, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_a0 = a0; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic a0, output logic [7:0] d);
    host_a0 = a0;
    #1 d = host_rdata;
  endtask

  task automatic rd_chk(string req, logic a0, logic [7:0] exp);
    logic [7:0] d;
    rd(a0, d);
    check(req, d, exp);
  endtask

  // driver: pushes the expected vector, then pulses the acknowledge
  task automatic ack(string req, logic [7:0] exp);
    @(negedge clk);
    irq_ack = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    #2 -> mon_ev;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // monitor: compares the vector the design presents during the acknowledge
  always @(mon_ev) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(t, ack_vec, e);
  end

  task automatic configure(logic [7:0] first, logic [7:0] b, logic [7:0] mode);
    wr(0, first);
    wr(1, b);
    wr(1, 8'h04);
    if (first[0]) wr(1, mode);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rd_chk("R1 mask", 1, 8'hFF);
    rd_chk("R1 request reg", 0, 8'h00);
    wr(0, 8'h0B);
    rd_chk("R1 isr", 0, 8'h00);
    wr(0, 8'h0A);

    // R2 configuration with mode byte, base 0x20
    configure(8'h11, 8'h20, 8'h01);
    wr(1, 8'hA5);
    rd_chk("R3 mask readback", 1, 8'hA5);
    wr(1, 8'h00);

    // R4/R5/R10 edge lines 4 and 7
    irq_in = 8'h90; tick(2);
    check("R3 unmasked raises", {7'd0, irq_out}, 8'h01);
    ack("R4 vector line4", 8'h24);
    wr(0, 8'h0B);
    rd_chk("R7 isr read", 0, 8'h10);
    check("R5 lower blocked", {7'd0, irq_out}, 8'h00);
    wr(0, 8'h64);
    check("R6 retire frees lower", {7'd0, irq_out}, 8'h01);
    ack("R4 vector line7", 8'h27);
    rd_chk("R5 isr line7", 0, 8'h80);
    wr(0, 8'h0A);
    rd_chk("R10 held high no relatch", 0, 8'h00);
    wr(0, 8'h67);
    irq_in = 8'h00; tick(1);
    irq_in = 8'h10; tick(2);
    check("R10 re-rise latches", {7'd0, irq_out}, 8'h01);
    ack("R10 vector", 8'h24);
    wr(0, 8'h64);
    irq_in = 8'h00; tick(1);

    // R5 nesting: higher request over lower in-service
    irq_in = 8'h20; tick(2);
    ack("R5 vector line5", 8'h25);
    irq_in = 8'h22; tick(2);
    check("R5 higher not blocked", {7'd0, irq_out}, 8'h01);
    ack("R5 vector line1", 8'h21);
    wr(0, 8'h0B);
    rd_chk("R5 isr nested", 0, 8'h22);
    wr(0, 8'h61);
    rd_chk("R6 only bit1", 0, 8'h20);
    wr(0, 8'h65);
    irq_in = 8'h00;
    wr(0, 8'h0A);

    // R3 masking
    wr(1, 8'h08);
    irq_in = 8'h08; tick(2);
    check("R3 masked line quiet", {7'd0, irq_out}, 8'h00);
    rd_chk("R7 irr read", 0, 8'h08);
    wr(1, 8'hFF);
    check("R3 all masked", {7'd0, irq_out}, 8'h00);
    wr(1, 8'h00);
    check("R3 unmask raises", {7'd0, irq_out}, 8'h01);
    ack("R4 vector line3", 8'h23);
    wr(0, 8'h63);
    irq_in = 8'h00;

    // R9 spurious with line 7 masked
    wr(1, 8'h80);
    irq_in = 8'h04; tick(2);
    check("R9 request seen", {7'd0, irq_out}, 8'h01);
    irq_in = 8'h00; tick(2);
    check("R10 withdrawn", {7'd0, irq_out}, 8'h00);
    ack("R9 spurious vector", 8'h27);
    wr(0, 8'h0B);
    rd_chk("R9 isr untouched", 0, 8'h00);
    wr(0, 8'h0A);
    wr(1, 8'h00);

    // R11 level line 6
    trig_level = 8'h40;
    irq_in = 8'h40; tick(2);
    rd_chk("R11 irr level", 0, 8'h40);
    ack("R11 vector line6", 8'h26);
    rd_chk("R11 irr follows", 0, 8'h40);
    check("R11 blocked in service", {7'd0, irq_out}, 8'h00);
    wr(0, 8'h66);
    check("R11 refires", {7'd0, irq_out}, 8'h01);
    irq_in = 8'h00; tick(2);
    check("R11 drops", {7'd0, irq_out}, 8'h00);
    // R11 reserved edge-only line 0
    trig_level = 8'h01;
    irq_in = 8'h01; tick(2);
    ack("R11 vector line0", 8'h20);
    wr(0, 8'h60);
    tick(1);
    check("R11 edge-only no refire", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h00; trig_level = 8'h00; tick(1);

    // R12 re-init clears state; R8 automatic retire
    irq_in = 8'h20; tick(2);
    ack("R4 vector line5 pre-init", 8'h25);
    irq_in = 8'h00;
    wr(0, 8'h0B);
    rd_chk("R12 isr before init", 0, 8'h20);
    configure(8'h11, 8'h40, 8'h03);
    rd_chk("R12 mask all", 1, 8'hFF);
    irq_in = 8'h08; tick(2);
    rd_chk("R12 read select irr", 0, 8'h08);
    wr(0, 8'h0B);
    rd_chk("R12 isr cleared", 0, 8'h00);
    wr(1, 8'h00);
    ack("R8 vector base 0x40", 8'h43);
    rd_chk("R8 isr stays clear", 0, 8'h00);
    check("R8 no refire", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h00;

    // R2 configuration without mode byte
    configure(8'h10, 8'h60, 8'h00);
    wr(1, 8'h3C);
    rd_chk("R2 mask after 3 bytes", 1, 8'h3C);
    wr(1, 8'h00);
    irq_in = 8'h02; tick(2);
    ack("R2 base 0x60", 8'h61);
    wr(0, 8'h0B);
    rd_chk("R2 auto retire off", 0, 8'h02);
    irq_in = 8'h00;
    tick(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule